// File: doc/BRIEF.md
# Two-Mode Successive-Approximation Sequencer

This block sequences the digital side of a column successive-approximation converter in a line-scan sensor where several exposures of the same scene line are added together. It supports two kinds of conversion. A coarse conversion resolves only the upper part of the code, meaning the four nominal high bits plus one redundant bit. A fine conversion starts from a coarse code supplied from outside. It places that code in the upper DAC bits and resolves only the lower bits, so it takes fewer cycles than a conversion that starts at the MSB. A typical line takes a few coarse conversions, whose results the surrounding logic averages into a preset, followed by a run of fine conversions that reuse that preset.

Each conversion begins with a sampling phase of a configurable number of cycles. During this phase `sample_o` is high. The bit decisions follow, one per cycle. In each decision cycle the bit under trial is driven high on the DAC word, and the comparator answer received at the end of that cycle decides whether the bit stays. A single-cycle `done_o` then presents the result. The sequencer latches the mode and the preset when it accepts a start. It ignores any further start until the conversion has fully ended.

Top module: `sar_conv_seq`

## Requirements
- R1: While reset is held, and directly after it, `done_o`, `sample_o`, `result_o` and `dac_o` are all zero.
- R2: After the clock edge that accepts a start (start_i high while idle), `sample_o` is high for exactly SAMPLE_CYC cycles and low in the first decision cycle.
- R3: A coarse conversion (fine_i=0) makes 5 decisions and a fine one (fine_i=1) makes 6. `done_o` goes high on rising edge SAMPLE_CYC+5 (coarse) or SAMPLE_CYC+6 (fine) counted from the accepting edge.
- R4: A coarse result appears on `result_o[4:0]` as the bits 9..5 of the ideal 10-bit code, and `result_o[9:5]` is zero.
- R5: A fine result is a full 10-bit code whose bits 9..6 equal preset_i[4:1]. Bits 5..0 are resolved against the input, so they saturate at 0 or 63 when the input lies outside the window the preset selects.
- R6: In each decision cycle the trial bit is high on `dac_o`. It is cleared in later cycles if comp_i was 1 (DAC above input) at the end of its cycle, and kept otherwise.
- R7: `done_o` is high for exactly one cycle per conversion, and `result_o` is zero whenever `done_o` is low.
- R8: A start raised while a conversion is in progress, including its done cycle, causes no new sampling phase and no extra done.
- R9: A change of `fine_i` or `preset_i` after the accepting edge has no effect on that conversion.
- R10: In fine mode the first decision cycle drives `dac_o` = {preset_i[4:1], 1, 00000}. In coarse mode it drives 10'b1000000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| fine_i | input | 1 | 1 selects a fine conversion, 0 a coarse one |
| preset_i | input | 5 | Coarse code for fine mode; bits 4..1 are loaded and bit 0 is the redundant bit |
| comp_i | input | 1 | Comparator answer, 1 when the DAC level is above the input |
| dac_o | output | 10 | DAC control word, including the bit under trial |
| sample_o | output | 1 | High during the sampling phase |
| result_o | output | 10 | Conversion result, valid only while done_o is high |
| done_o | output | 1 | One-cycle end-of-conversion strobe |

## Verification
The bench builds the block with its default widths: a 10-bit word, four nominal coarse bits plus the redundant bit, and a two-cycle sampling phase. This gives conversions of 8 and 9 cycles. At that length the bench can sweep all 1024 input levels in coarse mode and every one of the 32 preset codes in fine mode, with inputs placed below, inside and above the preset window. The short sampling phase also keeps each cycle of the sampling and decision sequence within exact per-cycle checks. Those checks include the DAC word in the first two decision cycles and start pulses that land in the middle of a conversion or in its done cycle.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SAMP = 2'd1,
      PH_CONV = 2'd2,
      PH_FIN  = 2'd3
   } phase_t;

endpackage

// File: rtl/sar_seq_timer.sv
module sar_seq_timer
   import sar_seq_pkg::*;
#(
   parameter int SAMPLE_CYC = 2,
   parameter int COARSE_DEC = 5,
   parameter int FINE_DEC   = 6,
   parameter int CNT_W      = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             fine_i,
   output phase_t           phase_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             accept_o
);

   phase_t           phase_q;
   logic [CNT_W-1:0] cnt_q;

   assign accept_o = (phase_q == PH_IDLE) && start_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (start_i) begin
                  phase_q <= PH_SAMP;
                  cnt_q   <= CNT_W'(SAMPLE_CYC - 1);
               end
            end
            PH_SAMP: begin
               if (cnt_q == '0) begin
                  phase_q <= PH_CONV;
                  cnt_q   <= fine_i ? CNT_W'(FINE_DEC - 1) : CNT_W'(COARSE_DEC - 1);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_CONV: begin
               if (cnt_q == '0) phase_q <= PH_FIN;
               else             cnt_q   <= cnt_q - 1'b1;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign phase_o = phase_q;
   assign cnt_o   = cnt_q;

endmodule

// File: rtl/sar_seq_word.sv
module sar_seq_word #(
   parameter int DATA_W     = 10,
   parameter int NOM_COARSE = 4,
   parameter int IDX_W      = 4
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  load_i,
   input  logic                  fine_i,
   input  logic [NOM_COARSE-1:0] preset_top_i,
   input  logic                  decide_i,
   input  logic [IDX_W-1:0]      idx_i,
   input  logic                  comp_i,
   output logic [DATA_W-1:0]     word_o,
   output logic [DATA_W-1:0]     dac_o
);

   localparam int LOW_W = DATA_W - NOM_COARSE;

   logic [DATA_W-1:0] init_w;
   logic [DATA_W-1:0] word_q;
   logic [DATA_W-1:0] trial_w;

   assign init_w = fine_i ? {preset_top_i, {LOW_W{1'b0}}} : '0;

   for (genvar g = 0; g < DATA_W; g++) begin : g_bit
      assign trial_w[g] = decide_i && (idx_i == IDX_W'(g));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)          word_q[g] <= 1'b0;
         else if (load_i)      word_q[g] <= init_w[g];
         else if (trial_w[g])  word_q[g] <= ~comp_i;
      end
   end

   assign word_o = word_q;
   assign dac_o  = word_q | trial_w;

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
   import sar_seq_pkg::*;
#(
   parameter int DATA_W     = 10,
   parameter int NOM_COARSE = 4,
   parameter int EXTRA_BIT  = 1,
   parameter int SAMPLE_CYC = 2
) (
   input  logic                            clk_i,
   input  logic                            rst_ni,
   input  logic                            start_i,
   input  logic                            fine_i,
   input  logic [NOM_COARSE+EXTRA_BIT-1:0] preset_i,
   input  logic                            comp_i,
   output logic [DATA_W-1:0]               dac_o,
   output logic                            sample_o,
   output logic [DATA_W-1:0]               result_o,
   output logic                            done_o
);

   localparam int COARSE_W   = NOM_COARSE + EXTRA_BIT;
   localparam int COARSE_DEC = COARSE_W;
   localparam int FINE_DEC   = DATA_W - NOM_COARSE;
   localparam int COARSE_LSB = DATA_W - COARSE_W;
   localparam int MAX_A      = (SAMPLE_CYC > FINE_DEC) ? SAMPLE_CYC : FINE_DEC;
   localparam int CNT_MAX    = (MAX_A > COARSE_DEC) ? MAX_A : COARSE_DEC;
   localparam int CNT_W      = $clog2(CNT_MAX + 1);
   localparam int IDX_W      = $clog2(DATA_W);

   if (SAMPLE_CYC < 1) begin : g_bad_samp
      $error("SAMPLE_CYC must be at least 1");
   end
   if (NOM_COARSE < 1 || COARSE_W >= DATA_W) begin : g_bad_coarse
      $error("coarse width must lie strictly inside the data word");
   end
   if (EXTRA_BIT != 0 && EXTRA_BIT != 1) begin : g_bad_extra
      $error("EXTRA_BIT must be 0 or 1");
   end

   phase_t                phase_w;
   logic [CNT_W-1:0]      cnt_w;
   logic                  accept_w;
   logic                  fine_q;
   logic [NOM_COARSE-1:0] preset_top_q;
   logic [NOM_COARSE-1:0] preset_top_w;
   logic [IDX_W-1:0]      idx_w;
   logic [DATA_W-1:0]     word_w;
   logic [DATA_W-1:0]     value_w;

   if (EXTRA_BIT == 1) begin : g_redund
      logic unused_redund_bit;
      assign preset_top_w      = preset_i[COARSE_W-1:1];
      assign unused_redund_bit = preset_i[0];
   end else begin : g_plain
      assign preset_top_w = preset_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fine_q       <= 1'b0;
         preset_top_q <= '0;
      end else if (accept_w) begin
         fine_q       <= fine_i;
         preset_top_q <= preset_top_w;
      end
   end

   sar_seq_timer #(
      .SAMPLE_CYC (SAMPLE_CYC),
      .COARSE_DEC (COARSE_DEC),
      .FINE_DEC   (FINE_DEC),
      .CNT_W      (CNT_W)
   ) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (start_i),
      .fine_i   (fine_q),
      .phase_o  (phase_w),
      .cnt_o    (cnt_w),
      .accept_o (accept_w)
   );

   assign idx_w = fine_q ? IDX_W'(cnt_w) : IDX_W'(cnt_w) + IDX_W'(COARSE_LSB);

   sar_seq_word #(
      .DATA_W     (DATA_W),
      .NOM_COARSE (NOM_COARSE),
      .IDX_W      (IDX_W)
   ) u_word (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .load_i       (accept_w),
      .fine_i       (fine_i),
      .preset_top_i (preset_top_w),
      .decide_i     (phase_w == PH_CONV),
      .idx_i        (idx_w),
      .comp_i       (comp_i),
      .word_o       (word_w),
      .dac_o        (dac_o)
   );

   assign value_w  = fine_q ? word_w
                            : {{(DATA_W-COARSE_W){1'b0}}, word_w[DATA_W-1 -: COARSE_W]};
   assign done_o   = (phase_w == PH_FIN);
   assign sample_o = (phase_w == PH_SAMP);
   assign result_o = done_o ? value_w : '0;

endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
   parameter int DATA_W     = 10,
   parameter int NOM_COARSE = 4,
   parameter int EXTRA_BIT  = 1
) (
   input logic                  clk_i,
   input logic                  rst_ni,
   input logic                  start_i,
   input logic                  done_o,
   input logic                  sample_o,
   input logic [DATA_W-1:0]     result_o,
   input logic                  fine_q,
   input logic [NOM_COARSE-1:0] preset_top_q
);

   localparam int COARSE_W = NOM_COARSE + EXTRA_BIT;

   // R7
   done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R7
   result_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> (result_o == '0));

   // R2
   sample_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sample_o) |-> $past(start_i));

   // R8
   no_restart_in_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !sample_o);

   // R9
   mode_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sample_o && !$rose(sample_o)) |-> $stable(fine_q));

   // R4
   coarse_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !fine_q) |-> (result_o[DATA_W-1:COARSE_W] == '0));

   // R5
   fine_top_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && fine_q) |-> (result_o[DATA_W-1 -: NOM_COARSE] == preset_top_q));

endmodule

bind sar_conv_seq sar_conv_seq_chk #(
   .DATA_W     (DATA_W),
   .NOM_COARSE (NOM_COARSE),
   .EXTRA_BIT  (EXTRA_BIT)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .start_i      (start_i),
   .done_o       (done_o),
   .sample_o     (sample_o),
   .result_o     (result_o),
   .fine_q       (fine_q),
   .preset_top_q (preset_top_q)
);

// File: tb/sar_conv_seq_test.sv
`timescale 1ns/1ps
module sar_conv_seq_test;

   localparam int H = 2;

   typedef struct {
      logic [9:0] res;
      int         done_cyc;
      string      req;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       fine = 1'b0;
   logic [4:0] preset = '0;
   logic [9:0] vin = '0;
   logic       comp;
   logic [9:0] dac;
   logic       sample;
   logic [9:0] result;
   logic       done;

   int    cyc = 0;
   int    n_chk = 0;
   int    n_fail = 0;
   logic  prev_done = 1'b0;
   bit    finished = 1'b0;
   item_t sb[$];

   always #2 clk = ~clk;

   assign comp = (dac > vin);

   sar_conv_seq #(.SAMPLE_CYC(H)) uut (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .start_i  (start),
      .fine_i   (fine),
      .preset_i (preset),
      .comp_i   (comp),
      .dac_o    (dac),
      .sample_o (sample),
      .result_o (result),
      .done_o   (done)
   );

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [9:0] fine_expect(input logic [4:0] p, input logic [9:0] v);
      logic [9:0] base;
      base = {p[4:1], 6'd0};
      if (v < base)              return base;
      if (v > base + 10'd63)     return base + 10'd63;
      return v;
   endfunction

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            if (sb.size() == 0) begin
               check(1'b0, "R8 unexpected done", 1, 0);
            end else begin
               item_t it;
               it = sb.pop_front();
               check(result == it.res, it.req, int'(result), int'(it.res));
               check(cyc == it.done_cyc, "R3 latency", cyc, it.done_cyc);
            end
         end
         if (prev_done) begin
            check(!done, "R7 done width", int'(done), 0);
            check(result == '0, "R7 result quiet", int'(result), 0);
         end
         prev_done = done;
      end
   end

   // mode 0: plain, 1: start mid-conversion with other inputs, 2: start in done cycle
   task automatic run_conv(input bit f, input logic [4:0] p, input logic [9:0] v, input int mode);
      item_t      it;
      logic [9:0] first;
      logic [9:0] second;
      logic [9:0] base;
      @(negedge clk);
      vin    = v;
      fine   = f;
      preset = p;
      start  = 1'b1;
      it.res      = f ? fine_expect(p, v) : {5'd0, v[9:5]};
      it.done_cyc = cyc + 1 + H + (f ? 6 : 5);
      it.req      = f ? "R5 fine result" : "R4 coarse result";
      sb.push_back(it);
      base = {p[4:1], 6'd0};
      if (f) begin
         first  = {p[4:1], 1'b1, 5'd0};
         second = {p[4:1], (v >= base + 10'd32), 1'b1, 4'd0};
      end else begin
         first  = 10'b1000000000;
         second = {(v >= 10'd512), 1'b1, 8'd0};
      end
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < H; i++) begin
         check(sample == 1'b1, "R2 sample high", int'(sample), 1);
         @(negedge clk);
      end
      check(sample == 1'b0, "R2 sample low", int'(sample), 0);
      check(dac == first, "R10 first trial word", int'(dac), int'(first));
      if (mode == 1) begin
         start  = 1'b1;
         fine   = ~f;
         preset = ~p;
      end
      @(negedge clk);
      start = 1'b0;
      check(dac == second, "R6 second trial word", int'(dac), int'(second));
      wait (sb.size() == 0);
      if (mode == 2) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 3; i++) begin
         check(sample == 1'b0, "R8 no restart", int'(sample), 0);
         @(negedge clk);
      end
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(done == 0 && sample == 0, "R1 reset ctrl", int'({done, sample}), 0);
      check(result == 0 && dac == 0, "R1 reset data", int'(result | dac), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 0 && sample == 0 && dac == 0, "R1 after reset", int'(dac), 0);

      // coarse corners and sweep (R4)
      run_conv(1'b0, 5'd0, 10'd0, 0);
      run_conv(1'b0, 5'd0, 10'd1023, 0);
      run_conv(1'b0, 5'd0, 10'd517, 0);
      for (int v = 0; v < 1024; v++) run_conv(1'b0, 5'd0, 10'(v), 0);

      // fine: inside, above and below the preset window (R5)
      run_conv(1'b1, 5'b10000, 10'd517, 0);
      run_conv(1'b1, 5'b10001, 10'd600, 0);
      run_conv(1'b1, 5'b11110, 10'd100, 0);
      run_conv(1'b1, 5'd0, 10'd63, 0);
      run_conv(1'b1, 5'd31, 10'd1023, 0);
      for (int p = 0; p < 32; p++) begin
         run_conv(1'b1, 5'(p), 10'((p / 2) * 64 + 17), 0);
         run_conv(1'b1, 5'(p), 10'((p * 97) % 1024), 0);
      end

      // R8 / R9: disturbances during a conversion and in its done cycle
      run_conv(1'b0, 5'd7, 10'd333, 1);
      run_conv(1'b1, 5'b01010, 10'd345, 1);
      run_conv(1'b1, 5'b00110, 10'd200, 2);
      run_conv(1'b0, 5'd0, 10'd900, 2);

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule